// File: doc/BRIEF.md
# Cascaded timestamp interrupt aggregator

This block gathers the timestamp-capture events of a three-port switch into one interrupt line. There are nine sources: a capture on receive and a capture on transmit for each of ports 0, 1 and 2, two GPIO capture inputs, and the timestamp timer. Each source arrives as a one-cycle pulse and latches a status bit. Software clears a status bit by writing 1 to it.

A first-level register holds the nine status bits and nine matching enable bits. A status bit always shows its raw event state. The enable affects only whether that bit counts toward the summary. The OR of the enabled status bits appears as a read-only summary bit in a system status register. A separate system enable bit must also be set before the interrupt output goes high. On port 0, "receive" means traffic from the switch fabric toward the host, and "transmit" means traffic from the host toward the fabric.

Software reaches the three registers through a plain single-cycle write strobe and a combinational read port.

Top module: `tsirq_aggregator`

## Requirements
- R1: After reset, every status bit, every first-level enable bit and the system enable bit are 0. All three registers read as zero and `irq_o` is low.
- R2: An event pulse on `evt_i[n]` sets status bit n of the first-level register (address 0x198) at the next clock edge, whatever the enable setting. The source for each bit is: 0 timer, 1 GPIO8, 2 GPIO9, 3 port 0 transmit, 4 port 0 receive, 5 port 1 transmit, 6 port 1 receive, 7 port 2 transmit, 8 port 2 receive.
- R3: A write to 0x198 clears each status bit in 8:0 whose data bit is 1 and leaves unchanged each status bit whose data bit is 0.
- R4: When an event pulse and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R5: Every write to 0x198 loads data bits 24:16 into the enable bits, and the register reads them back at 24:16. Enable bit n+16 belongs to status bit n.
- R6: Bits 31:25 and 15:9 of 0x198 read as 0 whatever was written. Writes to any address other than 0x198 and 0x05C change no register.
- R7: The system status register (address 0x058) reads bit 29 as 1 exactly when some status bit has its enable set, and reads every other bit as 0. The register is read-only. Bit 29 drops as soon as the contributing status bits are cleared or disabled.
- R8: A write to the system enable register (address 0x05C) loads data bit 29 into it. The register reads that bit back at bit 29 and reads every other bit as 0.
- R9: `irq_o` is high exactly when system status bit 29 and system enable bit 29 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 12 | Register byte address, used for both read and write |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_i | input | 9 | Event pulses, one bit per source, synchronous to `clk_i` |
| irq_o | output | 1 | Interrupt request, active-high level |

## Verification
A status flop that is stuck, or that loses to a same-cycle clear, shows on the first read of 0x198 after the pulse. It also shows as a wrong summary bit one edge after the event. An enable or system-enable bit that loads wrongly shows at `irq_o` in the cycle after the write, because the summary and the output gate add no register. For that reason each scenario reads both registers and samples `irq_o` one edge after every stimulus. The tests move through enable masks that do and do not cover the pending sources, so that a summary built from raw status alone, or from enables alone, gives a different level.

// File: rtl/tsirq_pkg.sv
package tsirq_pkg;

   // Source index of each capture event within the status and enable fields
   typedef enum int unsigned {
      SRC_TIMER    = 0,
      SRC_GPIO_A   = 1,
      SRC_GPIO_B   = 2,
      SRC_P0_TX    = 3,
      SRC_P0_RX    = 4,
      SRC_P1_TX    = 5,
      SRC_P1_RX    = 6,
      SRC_P2_TX    = 7,
      SRC_P2_RX    = 8
   } tsirq_src_e;

   localparam int unsigned TSIRQ_NUM_SRC = 9;

   // Mask with bits [lsb +: width] set, used for readback field placement
   function automatic logic [31:0] field_mask(input int unsigned lsb, input int unsigned width);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < width; i++) m[lsb + i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/tsirq_src_cell.sv
module tsirq_src_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic clr_i,
   input  logic ena_we_i,
   input  logic ena_d_i,
   output logic sts_o,
   output logic ena_o
);

   logic sts_q;
   logic ena_q;

   // An event takes priority over a clear arriving in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sts_q <= 1'b0;
      end else if (evt_i) begin
         sts_q <= 1'b1;
      end else if (clr_i) begin
         sts_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ena_q <= 1'b0;
      end else if (ena_we_i) begin
         ena_q <= ena_d_i;
      end
   end

   assign sts_o = sts_q;
   assign ena_o = ena_q;

endmodule

// File: rtl/tsirq_reduce.sv
module tsirq_reduce #(
   parameter int unsigned WIDTH = 9
) (
   input  logic [WIDTH-1:0] sts_i,
   input  logic [WIDTH-1:0] ena_i,
   output logic             any_o
);

   logic [WIDTH-1:0] masked;
   assign masked = sts_i & ena_i;

   if (WIDTH == 1) begin : g_single
      assign any_o = masked[0];
   end else begin : g_multi
      assign any_o = |masked;
   end

endmodule

// File: rtl/tsirq_sys_gate.sv
module tsirq_sys_gate #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ena_we_i,
   input  logic ena_d_i,
   input  logic summary_i,
   output logic sys_ena_o,
   output logic irq_o
);

   logic sys_ena_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sys_ena_q <= 1'b0;
      end else if (ena_we_i) begin
         sys_ena_q <= ena_d_i;
      end
   end

   assign sys_ena_o = sys_ena_q;

   if (OUT_REG) begin : g_flop_out
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= summary_i & sys_ena_q;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_comb_out
      assign irq_o = summary_i & sys_ena_q;
   end

endmodule

// File: rtl/tsirq_aggregator.sv
module tsirq_aggregator
   import tsirq_pkg::*;
#(
   parameter int unsigned          ADDR_W       = 12,
   parameter int unsigned          DATA_W       = 32,
   parameter int unsigned          NUM_SRC      = TSIRQ_NUM_SRC,
   parameter int unsigned          STS_LSB      = 0,
   parameter int unsigned          ENA_LSB      = 16,
   parameter int unsigned          SUMMARY_BIT  = 29,
   parameter logic [ADDR_W-1:0]    L1_ADDR      = 12'h198,
   parameter logic [ADDR_W-1:0]    SYS_STS_ADDR = 12'h058,
   parameter logic [ADDR_W-1:0]    SYS_ENA_ADDR = 12'h05C,
   parameter bit                   OUT_REG      = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic              irq_o
);

   localparam int unsigned STS_TOP = STS_LSB + NUM_SRC;
   localparam int unsigned ENA_TOP = ENA_LSB + NUM_SRC;

   // Elaboration-time parameter checks
   if (NUM_SRC == 0) begin : g_chk_src
      $error("tsirq_aggregator: NUM_SRC must be nonzero");
   end
   if (STS_TOP > ENA_LSB) begin : g_chk_overlap
      $error("tsirq_aggregator: status field overlaps enable field");
   end
   if (ENA_TOP > DATA_W) begin : g_chk_ena
      $error("tsirq_aggregator: enable field exceeds data width");
   end
   if (SUMMARY_BIT >= DATA_W) begin : g_chk_sum
      $error("tsirq_aggregator: summary bit outside data width");
   end
   if (L1_ADDR == SYS_STS_ADDR || L1_ADDR == SYS_ENA_ADDR || SYS_STS_ADDR == SYS_ENA_ADDR) begin : g_chk_addr
      $error("tsirq_aggregator: register addresses must differ");
   end

   logic l1_we;
   logic sys_ena_we;
   logic [NUM_SRC-1:0] sts_q;
   logic [NUM_SRC-1:0] ena_q;
   logic summary;
   logic sys_ena_q;
   logic wdata_unused;

   assign l1_we      = reg_wr_i && (reg_addr_i == L1_ADDR);
   assign sys_ena_we = reg_wr_i && (reg_addr_i == SYS_ENA_ADDR);
   assign wdata_unused = ^reg_wdata_i;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      tsirq_src_cell u_cell (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .evt_i    (evt_i[i]),
         .clr_i    (l1_we & reg_wdata_i[STS_LSB + i]),
         .ena_we_i (l1_we),
         .ena_d_i  (reg_wdata_i[ENA_LSB + i]),
         .sts_o    (sts_q[i]),
         .ena_o    (ena_q[i])
      );
   end

   tsirq_reduce #(
      .WIDTH (NUM_SRC)
   ) u_reduce (
      .sts_i (sts_q),
      .ena_i (ena_q),
      .any_o (summary)
   );

   tsirq_sys_gate #(
      .OUT_REG (OUT_REG)
   ) u_sys (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ena_we_i  (sys_ena_we),
      .ena_d_i   (reg_wdata_i[SUMMARY_BIT]),
      .summary_i (summary),
      .sys_ena_o (sys_ena_q),
      .irq_o     (irq_o)
   );

   // Combinational read decode
   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         L1_ADDR: begin
            reg_rdata_o[STS_LSB +: NUM_SRC] = sts_q;
            reg_rdata_o[ENA_LSB +: NUM_SRC] = ena_q;
         end
         SYS_STS_ADDR: reg_rdata_o[SUMMARY_BIT] = summary;
         SYS_ENA_ADDR: reg_rdata_o[SUMMARY_BIT] = sys_ena_q;
         default: reg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/tsirq_aggregator_chk.sv
module tsirq_aggregator_chk #(
   parameter int unsigned       ADDR_W       = 12,
   parameter int unsigned       DATA_W       = 32,
   parameter int unsigned       NUM_SRC      = 9,
   parameter int unsigned       STS_LSB      = 0,
   parameter int unsigned       ENA_LSB      = 16,
   parameter int unsigned       SUMMARY_BIT  = 29,
   parameter logic [ADDR_W-1:0] L1_ADDR      = 12'h198,
   parameter logic [ADDR_W-1:0] SYS_STS_ADDR = 12'h058,
   parameter bit                OUT_REG      = 1'b0
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [ADDR_W-1:0]  reg_addr_i,
   input logic               reg_wr_i,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [DATA_W-1:0]  reg_rdata_o,
   input logic [NUM_SRC-1:0] evt_i,
   input logic [NUM_SRC-1:0] sts_q,
   input logic [NUM_SRC-1:0] ena_q,
   input logic               sys_ena_q,
   input logic               irq_o
);

   logic l1_we;
   logic [NUM_SRC-1:0] wr_sts;
   logic [NUM_SRC-1:0] wr_ena;
   logic [DATA_W-1:0]  used_mask;
   logic pending;

   assign l1_we   = reg_wr_i && (reg_addr_i == L1_ADDR);
   assign wr_sts  = reg_wdata_i[STS_LSB +: NUM_SRC];
   assign wr_ena  = reg_wdata_i[ENA_LSB +: NUM_SRC];
   assign pending = |(sts_q & ena_q);

   always_comb begin
      used_mask = '0;
      used_mask[STS_LSB +: NUM_SRC] = '1;
      used_mask[ENA_LSB +: NUM_SRC] = '1;
   end

   // R2: every pulsed source is set after the edge
   p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

   // R4: a write-1 that meets an event on the same bit leaves that bit set
   p_evt_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1_we && ((evt_i & wr_sts) != '0)) |=> ((sts_q & $past(evt_i & wr_sts)) == $past(evt_i & wr_sts)));

   // R3: with no event, written ones are cleared
   p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1_we && (evt_i == '0)) |=> ((sts_q & $past(wr_sts)) == '0));

   // R3: with no event and no write, status holds
   p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l1_we && (evt_i == '0)) |=> $stable(sts_q));

   // R5: enables load from the write and hold otherwise
   p_ena_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1_we |=> (ena_q == $past(wr_ena)));
   p_ena_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l1_we |=> $stable(ena_q));

   // R6: reserved positions of the first-level register read zero
   p_rsv_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == L1_ADDR) |-> ((reg_rdata_o & ~used_mask) == '0));

   // R7: system status reads the enabled-status summary only
   p_sys_sts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == SYS_STS_ADDR) |-> (reg_rdata_o[SUMMARY_BIT] == pending &&
                                         $countones(reg_rdata_o) == (pending ? 1 : 0)));

   // R9: output level follows summary and system enable
   if (!OUT_REG) begin : g_comb_chk
      p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o == (pending && sys_ena_q));
   end else begin : g_flop_chk
      p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> $past(pending && sys_ena_q));
   end

endmodule

bind tsirq_aggregator tsirq_aggregator_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .NUM_SRC      (NUM_SRC),
   .STS_LSB      (STS_LSB),
   .ENA_LSB      (ENA_LSB),
   .SUMMARY_BIT  (SUMMARY_BIT),
   .L1_ADDR      (L1_ADDR),
   .SYS_STS_ADDR (SYS_STS_ADDR),
   .OUT_REG      (OUT_REG)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reg_addr_i  (reg_addr_i),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .evt_i       (evt_i),
   .sts_q       (sts_q),
   .ena_q       (ena_q),
   .sys_ena_q   (sys_ena_q),
   .irq_o       (irq_o)
);

// File: tb/tb_tsirq_aggregator.sv
module tb_tsirq_aggregator;

   localparam logic [11:0] A_L1  = 12'h198;
   localparam logic [11:0] A_SST = 12'h058;
   localparam logic [11:0] A_SEN = 12'h05C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [8:0]  evt = '0;
   logic        irq;

   int errors = 0;
   int checks = 0;

   logic [8:0] m_sts = '0;
   logic [8:0] m_ena = '0;
   logic       m_sena = 1'b0;

   always #2 clk = ~clk;

   tsirq_aggregator dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_addr_i  (addr),
      .reg_wr_i    (wr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .evt_i       (evt),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      if (a == A_L1) begin
         m_sts = m_sts & ~d[8:0];
         m_ena = d[24:16];
      end else if (a == A_SEN) begin
         m_sena = d[29];
      end
   endtask

   task automatic pulse(input logic [8:0] m);
      @(negedge clk);
      evt = m;
      @(negedge clk);
      evt = '0;
      m_sts = m_sts | m;
   endtask

   task automatic collide(input logic [8:0] m, input logic [31:0] d);
      @(negedge clk);
      evt = m; addr = A_L1; wdata = d; wr = 1'b1;
      @(negedge clk);
      evt = '0; wr = 1'b0;
      m_sts = (m_sts & ~d[8:0]) | m;
      m_ena = d[24:16];
   endtask

   // Compare all three registers and the output against the model
   task automatic check_all(input string req);
      logic [31:0] d;
      logic pend;
      pend = |(m_sts & m_ena);
      rd(A_L1, d);
      check({req, " l1"}, d, {7'b0, m_ena, 7'b0, m_sts});
      rd(A_SST, d);
      check({req, " sys_sts"}, d, {2'b0, pend, 29'b0});
      rd(A_SEN, d);
      check({req, " sys_ena"}, d, {2'b0, m_sena, 29'b0});
      check({req, " irq"}, {31'b0, irq}, {31'b0, pend & m_sena});
   endtask

   task automatic t_reset();
      check_all("R1 reset");
   endtask

   task automatic t_raw_status();
      for (int n = 0; n < 9; n++) begin
         pulse(9'(1 << n));
         check_all("R2 raw event");
         wr_reg(A_L1, 32'h0000_01FF);
         check_all("R3 clear all");
      end
   endtask

   task automatic t_w1c();
      pulse(9'h1FF);
      wr_reg(A_L1, 32'h0000_00AA);
      check_all("R3 partial clear");
      wr_reg(A_L1, 32'h0000_0000);
      check_all("R3 zero write keeps");
   endtask

   task automatic t_collision();
      collide(9'h008, 32'h0000_0028);
      check_all("R4 event beats clear");
   endtask

   task automatic t_enable_reserved();
      wr_reg(A_L1, 32'h0155_0000);
      check_all("R5 enable load");
      pulse(9'h1FF);
      wr_reg(A_L1, 32'hFFFF_FFFF);
      check_all("R6 reserved zero");
      pulse(9'h0C3);
      wr_reg(A_SST, 32'hFFFF_FFFF);
      check_all("R6 sys status write ignored");
      wr_reg(12'h100, 32'hFFFF_FFFF);
      check_all("R6 other address ignored");
      wr_reg(A_L1, 32'h0000_01FF);
      check_all("R5 disable all");
   endtask

   task automatic t_summary();
      wr_reg(A_L1, 32'h0010_0000);
      pulse(9'h004);
      check_all("R7 unenabled source");
      pulse(9'h010);
      check_all("R7 enabled source no sys ena");
      wr_reg(A_SEN, 32'hFFFF_FFFF);
      check_all("R8 sys enable set");
      check("R9 irq high", {31'b0, irq}, 32'd1);
      wr_reg(A_L1, 32'h0000_0000);
      check_all("R7 disable drops summary");
      wr_reg(A_L1, 32'h0010_0000);
      check_all("R9 reenable");
      wr_reg(A_L1, 32'h0010_0010);
      check_all("R7 clear drops summary");
      pulse(9'h100);
      wr_reg(A_L1, 32'h0100_0000);
      check_all("R9 port2 rx enabled");
      wr_reg(A_SEN, 32'hDFFF_FFFF);
      check_all("R8 sys enable clear");
      check("R9 irq low", {31'b0, irq}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raw_status();
      t_w1c();
      t_collision();
      t_enable_reserved();
      t_summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule